// File: doc/BRIEF.md
# Interleaved Channel Address Translator

This block converts a 40-bit system address into the address used inside one memory channel. A bank of eight programmable translation rules is held in the block. An interleave-range index input picks the rule that applies to the current address. The rule first moves the upper part of the address down by a programmable offset, so that each channel sees a contiguous space. It then deletes up to three low interleave bits (system bits 6, 7 and 8). The bits above each deleted bit move down to fill the gap. The result is bits 36:6 of that compacted value.

Each rule is one 32-bit register, read and written through a plain dword CSR port. Only a small set of bit-removal and divide-by-three pairings is supported. The block flags a selected rule that uses any other pairing, or that has reserved offset bits set, and still produces the computed address. A parameter makes the translation path either purely combinational or registered with one cycle of latency.

Top module: `chan_addr_xlate`

## Requirements
- R1: Rule k (k = 0..7) is reached at CSR byte address 0x80 + 4*k. A write to any other address, including a misaligned one, changes no rule, and a read from any other address returns zero.
- R2: Each rule register holds four fields. Bits 23:0 are the offset, bits 26:24 the removal mask and bit 27 the divide-by-three flag. Bits 31:28 are always zero. After reset every field of every rule is zero.
- R3: Writes to bits 31:28 of a rule are discarded, and those bits always read back as zero.
- R4: Intermediate bits 39:16 are system bits 39:16 minus the 24-bit offset, modulo 2^24. Any borrow out of bit 39 is dropped.
- R5: Intermediate bits 15:6 equal system bits 15:6.
- R6: Mask bit 2 deletes intermediate bit 8, mask bit 1 deletes bit 7 and mask bit 0 deletes bit 6. The bits above each deleted bit shift down to close the gap. Bit positions refer to the value before any deletion.
- R7: mem_addr[30:0] carries bits 36:6 of the value after the deletions. System bits 5:0 never reach the output.
- R8: illegal_rule is 1 when the selected rule's {mask, div3} pair is anything other than 000/0, 001/0, 011/0, 000/1 or 001/1.
- R9: illegal_rule is also 1 when offset bits 9:0 of the selected rule are not all zero. In every illegal case the computed address is still driven on mem_addr.
- R10: With REGISTERED=1, mem_addr and illegal_rule reflect the inputs and rules of the previous clock cycle, and they reset to zero. With REGISTERED=0 they follow the inputs combinationally.
- R11: rule_sel picks which of the eight rules controls the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Dword write strobe for the rule bank |
| csr_addr | input | 8 | CSR byte address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_addr (combinational) |
| rule_sel | input | 3 | Interleave-range index selecting the rule |
| sys_addr | input | 40 | System address to translate |
| mem_addr | output | 31 | Channel address, bits 36:6 |
| illegal_rule | output | 1 | Selected rule is unsupported or has reserved offset bits set |

## Verification
The bench builds the instance under test with REGISTERED=1 and eight rules. This exercises the one-cycle pipeline, its reset value, and the ordering between a rule write and a translation that is already in flight. A second instance with the default REGISTERED=0 shares the same CSR traffic, so the combinational variant is compared against the same expected values within the cycle. Filling all eight rules brings into reach the upper edge of the CSR window, the addresses just outside it, the offset wrap-around, and every legal and illegal removal pattern.

// File: rtl/chan_xlate_pkg.sv
package chan_xlate_pkg;

  localparam int SYS_W   = 40;
  localparam int OFS_W   = 24;
  localparam int MID_W   = SYS_W - 6;   // intermediate bits 39:6
  localparam int MEM_W   = 31;          // output bits 36:6
  localparam int RSV_OFS = 10;          // offset bits that must be zero

  typedef struct packed {
    logic [3:0]       zero_hi;
    logic             div3;
    logic [2:0]       strip;
    logic [OFS_W-1:0] offset;
  } rule_t;

  // Offset subtraction on bits 39:16, bits 15:6 unchanged; result is bits 39:6.
  function automatic logic [MID_W-1:0] offset_stage(logic [SYS_W-1:0] sa,
                                                    logic [OFS_W-1:0] ofs);
    logic [OFS_W-1:0] hi;
    hi = sa[SYS_W-1:16] - ofs;
    return {hi, sa[15:6]};
  endfunction

  // Delete bit k of the intermediate value and shift the upper part down.
  function automatic logic [MID_W-1:0] drop_bit(logic [MID_W-1:0] m, int unsigned k);
    logic [MID_W-1:0] low_mask;
    low_mask = (MID_W'(1) << k) - MID_W'(1);
    return ((m >> (k + 1)) << k) | (m & low_mask);
  endfunction

  // Removals applied from the highest position down so indices stay original.
  function automatic logic [MEM_W-1:0] squeeze(logic [MID_W-1:0] m, logic [2:0] strip);
    logic [MID_W-1:0] t;
    t = m;
    for (int i = 2; i >= 0; i--) begin
      if (strip[i]) t = drop_bit(t, i);
    end
    return t[MEM_W-1:0];
  endfunction

  function automatic logic pair_supported(rule_t r);
    case ({r.strip, r.div3})
      4'b000_0, 4'b001_0, 4'b011_0, 4'b000_1, 4'b001_1: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction

  function automatic logic rule_bad(rule_t r);
    return !pair_supported(r) || (|r.offset[RSV_OFS-1:0]);
  endfunction

  function automatic rule_t clean_write(logic [31:0] d);
    rule_t r;
    r = rule_t'(d);
    r.zero_hi = '0;
    return r;
  endfunction

endpackage

// File: rtl/xlate_rule_file.sv
module xlate_rule_file
  import chan_xlate_pkg::*;
#(
  parameter int          NUM_RULES = 8,
  parameter logic [7:0]  CSR_BASE  = 8'h80,
  parameter int          SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [7:0]       csr_addr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic [SEL_W-1:0] rule_sel,
  output rule_t            sel_rule,
  output logic             acc_hit
);

  localparam int SPAN = NUM_RULES * 4;

  logic [7:0]       rel;
  logic [SEL_W-1:0] idx;
  logic             in_win;
  rule_t            bank [NUM_RULES];

  assign rel    = csr_addr - CSR_BASE;
  assign in_win = (csr_addr >= CSR_BASE) && (int'(rel) < SPAN) && (rel[1:0] == 2'b00);
  assign idx    = rel[SEL_W+1:2];
  assign acc_hit = in_win;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    bank[g] <= '0;
      else if (csr_we && in_win && idx == SEL_W'(g)) bank[g] <= clean_write(csr_wdata);
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (in_win) csr_rdata = 32'(bank[idx]);
  end

  assign sel_rule = bank[rule_sel];

endmodule

// File: rtl/xlate_core.sv
module xlate_core
  import chan_xlate_pkg::*;
(
  input  logic [SYS_W-1:0] sys_addr,
  input  rule_t            rule,
  output logic [MID_W-1:0] mid_val,
  output logic [MEM_W-1:0] comb_addr,
  output logic             comb_bad
);

  assign mid_val   = offset_stage(sys_addr, rule.offset);
  assign comb_addr = squeeze(mid_val, rule.strip);
  assign comb_bad  = rule_bad(rule);

endmodule

// File: rtl/xlate_out_stage.sv
module xlate_out_stage #(
  parameter int W          = 32,
  parameter bit REGISTERED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_comb
    assign q = d;
  end

endmodule

// File: rtl/chan_addr_xlate.sv
module chan_addr_xlate
  import chan_xlate_pkg::*;
#(
  parameter int         NUM_RULES  = 8,
  parameter logic [7:0] CSR_BASE   = 8'h80,
  parameter bit         REGISTERED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [7:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [2:0]  rule_sel,
  input  logic [39:0] sys_addr,
  output logic [30:0] mem_addr,
  output logic        illegal_rule
);

  localparam int SEL_W = 3;

  rule_t            sel_rule;
  logic             acc_hit;
  logic [MID_W-1:0] mid_val;
  logic [MEM_W-1:0] comb_addr;
  logic             comb_bad;

  xlate_rule_file #(
    .NUM_RULES(NUM_RULES), .CSR_BASE(CSR_BASE), .SEL_W(SEL_W)
  ) u_rules (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rule_sel(rule_sel),
    .sel_rule(sel_rule), .acc_hit(acc_hit)
  );

  xlate_core u_core (
    .sys_addr(sys_addr), .rule(sel_rule), .mid_val(mid_val),
    .comb_addr(comb_addr), .comb_bad(comb_bad)
  );

  xlate_out_stage #(.W(MEM_W + 1), .REGISTERED(REGISTERED)) u_out (
    .clk(clk), .rst_n(rst_n), .d({comb_bad, comb_addr}),
    .q({illegal_rule, mem_addr})
  );

endmodule

// File: rtl/chan_addr_xlate_chk.sv
module chan_addr_xlate_chk
  import chan_xlate_pkg::*;
#(
  parameter bit REGISTERED = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_we,
  input logic [7:0]  csr_addr,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic [2:0]  rule_sel,
  input logic [39:0] sys_addr,
  input logic [30:0] mem_addr,
  input logic        illegal_rule,
  input rule_t       sel_rule,
  input logic        acc_hit,
  input logic [30:0] comb_addr,
  input logic        comb_bad
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic warm;
  assign warm = (age >= 2'd2);

  // R3
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:28] == 4'b0000);

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(csr_we) && $past(acc_hit) && csr_addr == $past(csr_addr))
      |-> csr_rdata == {4'b0000, $past(csr_wdata[27:0])});

  // R6
  plain_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rule.strip == 3'b000 && sel_rule.offset == '0) |-> comb_addr == sys_addr[36:6]);

  // R8
  bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rule.strip[2] || (sel_rule.strip == 3'b010) || (sel_rule.div3 && sel_rule.strip[1]))
      |-> comb_bad);

  // R10
  pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REGISTERED && warm && $stable(sys_addr) && $stable(rule_sel) && !$past(csr_we))
      |=> $stable(mem_addr) && $stable(illegal_rule));

  // R10
  comb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !REGISTERED |-> (mem_addr == comb_addr && illegal_rule == comb_bad));

endmodule

bind chan_addr_xlate chan_addr_xlate_chk #(.REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rule_sel(rule_sel),
  .sys_addr(sys_addr), .mem_addr(mem_addr), .illegal_rule(illegal_rule),
  .sel_rule(sel_rule), .acc_hit(acc_hit), .comb_addr(comb_addr),
  .comb_bad(comb_bad)
);

// File: tb/sim_chan_addr_xlate.sv
`timescale 1ns/1ps
module sim_chan_addr_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, rdata_c;
  logic [2:0]  rule_sel = '0;
  logic [39:0] sys_addr = '0;
  logic [30:0] mem_addr, mem_addr_c;
  logic        illegal_rule, illegal_c;

  always #10 clk = ~clk;   // 50 MHz

  chan_addr_xlate #(.REGISTERED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rule_sel(rule_sel),
    .sys_addr(sys_addr), .mem_addr(mem_addr), .illegal_rule(illegal_rule)
  );

  chan_addr_xlate u1 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rdata_c), .rule_sel(rule_sel),
    .sys_addr(sys_addr), .mem_addr(mem_addr_c), .illegal_rule(illegal_c)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [30:0] addr;
    logic        bad;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] shadow [8];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] ref_addr(logic [39:0] sa, logic [31:0] r);
    logic [33:0] m;
    logic [30:0] o;
    int j;
    m[33:10] = sa[39:16] - r[23:0];
    m[9:0]   = sa[15:6];
    o = '0;
    j = 0;
    for (int i = 0; i < 34; i++) begin
      if (i < 3 && r[24 + i]) continue;
      if (j < 31) o[j] = m[i];
      j++;
    end
    return o;
  endfunction

  function automatic logic ref_bad(logic [31:0] r);
    logic [2:0] rm;
    logic ok;
    rm = r[26:24];
    if (r[27]) ok = (rm == 3'd0) || (rm == 3'd1);
    else       ok = (rm == 3'd0) || (rm == 3'd1) || (rm == 3'd3);
    return !ok || (r[9:0] != 10'd0);
  endfunction

  task automatic csr_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    if (a >= 8'h80 && a <= 8'h9C && a[1:0] == 2'b00)
      shadow[(a - 8'h80) >> 2] = {4'b0000, d[27:0]};
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    csr_addr = a;
    #1;
    check(tag, 64'(csr_rdata), 64'(exp));
    check({tag, " comb"}, 64'(rdata_c), 64'(exp));
  endtask

  task automatic xlate(logic [2:0] sel, logic [39:0] sa, string tag);
    exp_t e;
    @(negedge clk);
    rule_sel = sel; sys_addr = sa;
    e.addr = ref_addr(sa, shadow[sel]);
    e.bad  = ref_bad(shadow[sel]);
    e.tag  = tag;
    q.push_back(e);
    #1;
    // R10 combinational variant follows inputs within the cycle
    check({tag, " R10 comb addr"}, 64'(mem_addr_c), 64'(e.addr));
    check({tag, " R10 comb flag"}, 64'(illegal_c), 64'(e.bad));
  endtask

  // Monitor: registered instance presents the result after the next rising edge.
  always begin
    @(posedge clk);
    #4;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " R10 addr"}, 64'(mem_addr), 64'(e.addr));
      check({e.tag, " R8 R9 flag"}, 64'(illegal_rule), 64'(e.bad));
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [39:0] pats [6];

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    pats[0] = 40'hAB_CDEF_1234;
    pats[1] = 40'h00_0000_0000;
    pats[2] = 40'hFF_FFFF_FFC0;
    pats[3] = 40'h12_3456_7FC0;
    pats[4] = 40'h00_0000_01C0;
    pats[5] = 40'h5A_A5A5_0140;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset value of registered output
    check("R10 reset addr", 64'(mem_addr), 64'd0);
    check("R10 reset flag", 64'(illegal_rule), 64'd0);
    rst_n = 1'b1;
    // R2 reset contents
    for (int k = 0; k < 8; k++) csr_read(8'(8'h80 + 4 * k), 32'd0, "R2 reset rule");

    // R2 R3 program all rules; top bits set in some writes
    csr_write(8'h80, 32'hF000_0000);
    csr_write(8'h84, 32'h0100_0400);
    csr_write(8'h88, 32'h3300_1C00);
    csr_write(8'h8C, 32'h0812_3400);
    csr_write(8'h90, 32'hA9FF_FC00);
    csr_write(8'h94, 32'h0200_0000);
    csr_write(8'h98, 32'h0000_0001);
    csr_write(8'h9C, 32'hFF80_0000);
    for (int k = 0; k < 8; k++)
      csr_read(8'(8'h80 + 4 * k), shadow[k], "R2 R3 readback");

    // R1 writes outside the window or misaligned are dropped
    csr_write(8'hA0, 32'h0123_4567);
    csr_write(8'h7C, 32'h0765_4321);
    csr_write(8'h82, 32'h0FFF_FFFF);
    csr_read(8'hA0, 32'd0, "R1 beyond window");
    csr_read(8'h7C, 32'd0, "R1 below window");
    csr_read(8'h82, 32'd0, "R1 misaligned");
    for (int k = 0; k < 8; k++)
      csr_read(8'(8'h80 + 4 * k), shadow[k], "R1 rules untouched");

    // R4 R5 R6 R7 R11 every rule with several address patterns
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 6; p++)
        xlate(3'(k), pats[p], $sformatf("R4 R5 R6 R7 R11 rule%0d pat%0d", k, p));

    // R4 borrow wraps: offset larger than upper bits
    xlate(3'd4, 40'h00_0001_0000, "R4 wrap");
    // R6 bits 6..8 isolated
    xlate(3'd2, 40'h00_0000_0040, "R6 bit6");
    xlate(3'd2, 40'h00_0000_0080, "R6 bit7");
    xlate(3'd2, 40'h00_0000_0200, "R6 bit9 moves");

    // R8 more unsupported pairs, R9 address still produced
    csr_write(8'h94, 32'h0B00_0000);
    xlate(3'd5, pats[0], "R8 strip011 div3");
    csr_write(8'h94, 32'h0400_0C00);
    xlate(3'd5, pats[3], "R8 strip100");
    csr_write(8'h98, 32'h0100_0600);
    xlate(3'd6, pats[5], "R9 reserved bits");

    // R10 write and translation in flight on the same edge
    xlate(3'd1, pats[0], "R10 before rewrite");
    csr_write(8'h84, 32'h0000_0000);
    xlate(3'd1, pats[0], "R10 after rewrite");

    repeat (3) @(negedge clk);
    check("R10 queue drained", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule